// File: doc/BRIEF.md
# Amplifier Protection Fault Manager

This block supervises the four half-bridges of a class-D power stage. It takes raw protection flags and turns them into per-half-bridge shutdown controls and two active-low status outputs. The flags are overload per channel, missing PWM per channel, bootstrap undervoltage per half-bridge, a set of supply undervoltage and power-on flags, and thermal warning and shutdown. Each event is treated in one of two ways. A global event stops every half-bridge. A channel event stops a group of half-bridges, and the output-mode code decides which group. Each event is also either latched or self-clearing. Latched events are released only when the external run request goes low and then high again.

A system controller drives the run request, which is active low. While the request is low, every half-bridge is held in Hi-Z and the fault output is forced inactive. The block will not release the stage from reset until a fixed delay has passed since the last falling edge of the fault output. That delay is 4 ms, counted in clock cycles derived from the `CLK_KHZ` parameter. Half-bridge bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. Every output is registered: an input sampled at a clock edge shows on the outputs right after that edge.

Top module: `amp_fault_mgr`

## Requirements
- R1: While `reset_req_n` is low, the cycle after it is sampled low shows `hb_hiz`=4'b1111, `fault_n`=1 and `run_en`=0, whatever flags are present. After `arst_n` is released the outputs are `hb_hiz`=4'b1111, `hs_off`=0, `fault_n`=1, `warn_n`=1 and `run_en`=0.
- R2: Any set bit of `supply_uv` while running gives `hb_hiz`=4'b1111 and `fault_n`=0 one cycle later. Both return to normal one cycle after the flags clear.
- R3: A one-cycle `therm_sd` while running gives all four half-bridges Hi-Z, with `fault_n`=0 and `warn_n`=0. This state is held until `reset_req_n` goes low and the stage is released again.
- R4: A one-cycle `ch_ovl` pulse while running drives the mode's group to Hi-Z and `fault_n` to 0. The state is latched and is cleared only by a low-then-high cycle of `reset_req_n`.
- R5: The mode grouping is as follows. Codes 3'b000, 3'b001, 3'b010, 3'b110 and 3'b111: A or B stops 4'b0011, and C or D stops 4'b1100. Code 3'b100: any channel stops 4'b1111. Codes 3'b101 and 3'b011: A or B stops 4'b0011, C stops 4'b0100, and D stops 4'b1100. Masks from several channels are ORed.
- R6: `hs_off` follows `bst_uv` bit for bit, one cycle later. It changes neither `hb_hiz` nor `fault_n`.
- R7: `pwm_stuck` on one to three channels applies the R5 grouping. All four stuck gives 4'b1111. Neither case pulls `fault_n` low, and both clear one cycle after the flags drop.
- R8: `warn_n` is 0 while `therm_warn` is 1 or a thermal shutdown is latched. A warning alone leaves `fault_n`=1 and the half-bridges switching.
- R9: After a falling edge of `fault_n`, `run_en` cannot rise until HOLD_CYC = CLK_KHZ*HOLD_US/1000 cycles have passed. With the request already high, `run_en` rises on the edge HOLD_CYC+1 edges after the edge that dropped `fault_n`. With no fault history, the release takes one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset of the block's registers, active low |
| reset_req_n | input | 1 | Run request from the system controller, active low |
| mode | input | 3 | Output-mode code selecting the shutdown grouping |
| ch_ovl | input | NCH | Overload shutdown flag per channel (latched) |
| pwm_stuck | input | NCH | Missing-PWM flag per channel (self-clearing) |
| bst_uv | input | NCH | Bootstrap undervoltage per half-bridge |
| supply_uv | input | NSUP | Supply undervoltage and power-on flags |
| therm_warn | input | 1 | Over-temperature warning |
| therm_sd | input | 1 | Over-temperature shutdown (latched) |
| hb_hiz | output | NCH | Half-bridge Hi-Z control, 1 = off |
| hs_off | output | NCH | High-side FET disable per half-bridge |
| fault_n | output | 1 | Shutdown fault status, active low |
| warn_n | output | 1 | Thermal warning status, active low |
| run_en | output | 1 | Stage released from reset |

## Verification
Some behaviours are checked by assertions on every clock. Every cycle after a low request is Hi-Z with the fault output inactive. A supply undervoltage forces every half-bridge off. The bootstrap flags pass straight to the high-side disables. A low fault output stays low while the request stays high and no supply flag is present. Missing PWM never pulls the fault output low. No release ever comes sooner than the hold-off after a fault falling edge. Other behaviours can only be shown by the bench scenarios. These are the exact group mask each mode code selects, that latched overload and thermal faults really clear after a reset cycle, and that the release comes on exactly the expected edge once the hold-off expires.

// File: rtl/amp_fm_pkg.sv
package amp_fm_pkg;

   localparam int unsigned HB_COUNT = 4;

   typedef enum logic [2:0] {
      OM_BRIDGE_2N   = 3'b000,
      OM_BRIDGE_1N   = 3'b001,
      OM_BRIDGE_BD   = 3'b010,
      OM_MIXED       = 3'b011,
      OM_PARALLEL    = 3'b100,
      OM_SINGLE      = 3'b101,
      OM_SPARE6      = 3'b110,
      OM_SPARE7      = 3'b111
   } out_mode_e;

   // Half-bridges stopped by a channel event on channel ch (bit 0 = A).
   function automatic logic [3:0] shut_group(input logic [2:0] m, input int unsigned ch);
      logic [3:0] pair;
      pair = (ch < 2) ? 4'b0011 : 4'b1100;
      case (m)
         OM_PARALLEL:          return 4'b1111;
         OM_SINGLE, OM_MIXED:  return (ch == 2) ? 4'b0100 : pair;
         default:              return pair;
      endcase
   endfunction

endpackage

// File: rtl/amp_fm_holdoff.sv
module amp_fm_holdoff #(
   parameter int unsigned HOLD_CYC = 400000
) (
   input  logic clk,
   input  logic arst_n,
   input  logic req_n,
   input  logic fall_evt,
   output logic run_q,
   output logic run_nx
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);

   logic [CW-1:0] wait_q;

   generate
      if (HOLD_CYC == 0) begin : g_bad_hold
         $error("amp_fm_holdoff: HOLD_CYC must be at least 1");
      end
   endgenerate

   assign run_nx = req_n && (run_q || (wait_q == '0));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run_q  <= 1'b0;
         wait_q <= '0;
      end else begin
         run_q <= run_nx;
         if (fall_evt)
            wait_q <= CW'(HOLD_CYC);
         else if (wait_q != '0)
            wait_q <= wait_q - 1'b1;
      end
   end

   AST_REQ_LOW_STOPS: assert property (@(posedge clk) disable iff (!arst_n)
      !req_n |=> !run_q);                                              // R1
   AST_WAIT_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
      (wait_q != '0) |=> (wait_q < CW'(HOLD_CYC)) || $past(fall_evt)); // R9

endmodule

// File: rtl/amp_fm_latch.sv
module amp_fm_latch #(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           arst_n,
   input  logic           run_nx,
   input  logic [NCH-1:0] ovl_in,
   input  logic           sd_in,
   output logic [NCH-1:0] ovl_nx,
   output logic [NCH-1:0] ovl_q,
   output logic           ote_nx,
   output logic           ote_q
);
   assign ovl_nx = run_nx ? (ovl_q | ovl_in) : '0;
   assign ote_nx = run_nx && (ote_q || sd_in);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         ovl_q <= '0;
         ote_q <= 1'b0;
      end else begin
         ovl_q <= ovl_nx;
         ote_q <= ote_nx;
      end
   end

endmodule

// File: rtl/amp_fm_group.sv
module amp_fm_group
   import amp_fm_pkg::*;
#(
   parameter int unsigned NCH = 4
) (
   input  logic [2:0]     mode,
   input  logic [NCH-1:0] src,
   output logic [NCH-1:0] mask
);
   logic [NCH-1:0] part [NCH];

   generate
      if (NCH != HB_COUNT) begin : g_bad_nch
         $error("amp_fm_group: grouping is defined for four half-bridges only");
      end
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         assign part[g] = src[g] ? NCH'(shut_group(mode, g)) : '0;
      end
   endgenerate

   always_comb begin
      mask = '0;
      for (int i = 0; i < NCH; i++)
         mask = mask | part[i];
   end

endmodule

// File: rtl/amp_fault_mgr.sv
module amp_fault_mgr #(
   parameter int unsigned NCH     = 4,
   parameter int unsigned NSUP    = 5,
   parameter int unsigned CLK_KHZ = 100000,
   parameter int unsigned HOLD_US = 4000
) (
   input  logic            clk,
   input  logic            arst_n,
   input  logic            reset_req_n,
   input  logic [2:0]      mode,
   input  logic [NCH-1:0]  ch_ovl,
   input  logic [NCH-1:0]  pwm_stuck,
   input  logic [NCH-1:0]  bst_uv,
   input  logic [NSUP-1:0] supply_uv,
   input  logic            therm_warn,
   input  logic            therm_sd,
   output logic [NCH-1:0]  hb_hiz,
   output logic [NCH-1:0]  hs_off,
   output logic            fault_n,
   output logic            warn_n,
   output logic            run_en
);
   localparam int unsigned HOLD_CYC = CLK_KHZ * HOLD_US / 1000;
   localparam int unsigned CKW      = $clog2(HOLD_CYC + 2);

   generate
      if (NSUP == 0) begin : g_bad_nsup
         $error("amp_fault_mgr: NSUP must be at least 1");
      end
      if (HOLD_CYC == 0) begin : g_bad_clk
         $error("amp_fault_mgr: CLK_KHZ*HOLD_US too small for a hold-off");
      end
   endgenerate

   logic           run_q, run_nx, fall_evt;
   logic [NCH-1:0] ovl_nx, ovl_q, grp_mask, hiz_nx;
   logic           ote_nx, ote_q, glob_off, fault_nx, warn_nx;

   amp_fm_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk(clk), .arst_n(arst_n), .req_n(reset_req_n),
      .fall_evt(fall_evt), .run_q(run_q), .run_nx(run_nx)
   );

   amp_fm_latch #(.NCH(NCH)) u_lat (
      .clk(clk), .arst_n(arst_n), .run_nx(run_nx),
      .ovl_in(ch_ovl), .sd_in(therm_sd),
      .ovl_nx(ovl_nx), .ovl_q(ovl_q), .ote_nx(ote_nx), .ote_q(ote_q)
   );

   amp_fm_group #(.NCH(NCH)) u_grp (
      .mode(mode), .src(ovl_nx | pwm_stuck), .mask(grp_mask)
   );

   assign glob_off = !run_nx || (|supply_uv) || ote_nx || (&pwm_stuck);
   assign hiz_nx   = glob_off ? '1 : grp_mask;
   assign fault_nx = !(run_nx && ((|supply_uv) || ote_nx || (|ovl_nx)));
   assign warn_nx  = !(therm_warn || ote_nx);
   assign fall_evt = fault_n && !fault_nx;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hb_hiz  <= '1;
         hs_off  <= '0;
         fault_n <= 1'b1;
         warn_n  <= 1'b1;
      end else begin
         hb_hiz  <= hiz_nx;
         hs_off  <= bst_uv;
         fault_n <= fault_nx;
         warn_n  <= warn_nx;
      end
   end

   assign run_en = run_q;

   // Independent gap counter: edges since the fault output was seen falling.
   logic           fault_d;
   logic [CKW-1:0] since_fall;
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         fault_d    <= 1'b1;
         since_fall <= CKW'(HOLD_CYC + 1);
      end else begin
         fault_d <= fault_n;
         if (fault_d && !fault_n)
            since_fall <= CKW'(1);
         else if (since_fall < CKW'(HOLD_CYC + 1))
            since_fall <= since_fall + 1'b1;
      end
   end

   AST_RST_HIZ: assert property (@(posedge clk) disable iff (!arst_n)
      !reset_req_n |=> (hb_hiz == '1) && fault_n && !run_en);            // R1
   AST_UV_GLOBAL: assert property (@(posedge clk) disable iff (!arst_n)
      (reset_req_n && run_en && (|supply_uv)) |=> (hb_hiz == '1) && !fault_n); // R2
   AST_FAULT_KEEP: assert property (@(posedge clk) disable iff (!arst_n)
      (reset_req_n && run_en && !fault_n && ($past(supply_uv) == '0)) |=> !fault_n); // R3
   AST_BST_PASS: assert property (@(posedge clk) disable iff (!arst_n)
      arst_n |=> hs_off == $past(bst_uv));                              // R6
   AST_STUCK_SILENT: assert property (@(posedge clk) disable iff (!arst_n)
      (reset_req_n && run_en && fault_n && (supply_uv == '0) && !therm_sd
       && (ch_ovl == '0)) |=> fault_n);                                 // R7
   AST_HOLD_GAP: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(run_en) |-> (since_fall >= CKW'(HOLD_CYC)));                // R9

endmodule

// File: tb/amp_fault_mgr_bench.sv
module amp_fault_mgr_bench;
   localparam int unsigned NCH = 4;
   localparam int unsigned NSUP = 5;
   localparam int unsigned CLK_KHZ = 10;
   localparam int unsigned HOLD = CLK_KHZ * 4000 / 1000;   // 40 cycles
   localparam int NV = 18;

   // {mode[3], stuck[4], bst[4], warn, uv, exp_hiz[4], exp_hs[4], exp_fault_n, exp_warn_n}
   localparam logic [22:0] VEC [NV] = '{
      {3'b000, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b1},
      {3'b000, 4'b0001, 4'b0000, 1'b0, 1'b0, 4'b0011, 4'b0000, 1'b1, 1'b1},
      {3'b000, 4'b0100, 4'b0000, 1'b0, 1'b0, 4'b1100, 4'b0000, 1'b1, 1'b1},
      {3'b100, 4'b0010, 4'b0000, 1'b0, 1'b0, 4'b1111, 4'b0000, 1'b1, 1'b1},
      {3'b101, 4'b0100, 4'b0000, 1'b0, 1'b0, 4'b0100, 4'b0000, 1'b1, 1'b1},
      {3'b101, 4'b1000, 4'b0000, 1'b0, 1'b0, 4'b1100, 4'b0000, 1'b1, 1'b1},
      {3'b101, 4'b0010, 4'b0000, 1'b0, 1'b0, 4'b0011, 4'b0000, 1'b1, 1'b1},
      {3'b011, 4'b0100, 4'b0000, 1'b0, 1'b0, 4'b0100, 4'b0000, 1'b1, 1'b1},
      {3'b011, 4'b0001, 4'b0000, 1'b0, 1'b0, 4'b0011, 4'b0000, 1'b1, 1'b1},
      {3'b011, 4'b1000, 4'b0000, 1'b0, 1'b0, 4'b1100, 4'b0000, 1'b1, 1'b1},
      {3'b010, 4'b1000, 4'b0000, 1'b0, 1'b0, 4'b1100, 4'b0000, 1'b1, 1'b1},
      {3'b000, 4'b1111, 4'b0000, 1'b0, 1'b0, 4'b1111, 4'b0000, 1'b1, 1'b1},
      {3'b000, 4'b0000, 4'b0101, 1'b0, 1'b0, 4'b0000, 4'b0101, 1'b1, 1'b1},
      {3'b000, 4'b0000, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0},
      {3'b001, 4'b0000, 4'b0000, 1'b0, 1'b1, 4'b1111, 4'b0000, 1'b0, 1'b1},
      {3'b000, 4'b0000, 4'b0000, 1'b1, 1'b1, 4'b1111, 4'b0000, 1'b0, 1'b0},
      {3'b101, 4'b0101, 4'b0000, 1'b0, 1'b0, 4'b0111, 4'b0000, 1'b1, 1'b1},
      {3'b111, 4'b0001, 4'b0000, 1'b0, 1'b0, 4'b0011, 4'b0000, 1'b1, 1'b1}
   };

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic reset_req_n = 1'b0;
   logic [2:0] mode = 3'b000;
   logic [NCH-1:0] ch_ovl = '0, pwm_stuck = '0, bst_uv = '0;
   logic [NSUP-1:0] supply_uv = '0;
   logic therm_warn = 1'b0, therm_sd = 1'b0;
   logic [NCH-1:0] hb_hiz, hs_off;
   logic fault_n, warn_n, run_en;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   amp_fault_mgr #(.NCH(NCH), .NSUP(NSUP), .CLK_KHZ(CLK_KHZ), .HOLD_US(4000)) u_amp_fault_mgr (
      .clk(clk), .arst_n(arst_n), .reset_req_n(reset_req_n), .mode(mode),
      .ch_ovl(ch_ovl), .pwm_stuck(pwm_stuck), .bst_uv(bst_uv),
      .supply_uv(supply_uv), .therm_warn(therm_warn), .therm_sd(therm_sd),
      .hb_hiz(hb_hiz), .hs_off(hs_off), .fault_n(fault_n), .warn_n(warn_n),
      .run_en(run_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // {hiz, hs_off, fault_n, warn_n, run_en}
   function automatic logic [31:0] outs();
      return {21'd0, hb_hiz, hs_off, fault_n, warn_n, run_en};
   endfunction

   function automatic logic [31:0] pk(input logic [3:0] h, input logic [3:0] s,
                                      input logic f, input logic w, input logic r);
      return {21'd0, h, s, f, w, r};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int t0, gap;
      repeat (3) @(negedge clk);
      arst_n = 1'b1;
      @(negedge clk);
      check("R1 reset state", outs(), pk(4'hF, 4'h0, 1'b1, 1'b1, 1'b0));
      supply_uv = 5'b00100;
      therm_sd = 1'b1;
      @(negedge clk);
      check("R1 flags ignored while request low", outs(), pk(4'hF, 4'h0, 1'b1, 1'b1, 1'b0));
      supply_uv = '0;
      therm_sd = 1'b0;
      reset_req_n = 1'b1;
      @(negedge clk);
      check("R9 release with no fault history", outs(), pk(4'h0, 4'h0, 1'b1, 1'b1, 1'b1));

      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         v = VEC[i];
         mode = v[22:20];
         pwm_stuck = v[19:16];
         bst_uv = v[15:12];
         therm_warn = v[11];
         supply_uv = v[10] ? NSUP'(1 << (i % NSUP)) : '0;
         @(negedge clk);
         check($sformatf("R5 R6 R7 R8 R2 vector %0d", i), outs(),
               pk(v[9:6], v[5:2], v[1], v[0], 1'b1));
      end
      pwm_stuck = '0; bst_uv = '0; therm_warn = 1'b0; supply_uv = '0; mode = 3'b000;
      @(negedge clk);
      check("R2 R7 self-clear", outs(), pk(4'h0, 4'h0, 1'b1, 1'b1, 1'b1));

      // R4: latched overload, grouped, cleared by a reset cycle, with hold-off
      ch_ovl = 4'b0001;
      @(negedge clk);
      t0 = cyc;
      check("R4 overload shutdown", outs(), pk(4'h3, 4'h0, 1'b0, 1'b1, 1'b1));
      ch_ovl = '0;
      repeat (3) @(negedge clk);
      check("R4 overload latched", outs(), pk(4'h3, 4'h0, 1'b0, 1'b1, 1'b1));
      reset_req_n = 1'b0;
      @(negedge clk);
      check("R1 request low", outs(), pk(4'hF, 4'h0, 1'b1, 1'b1, 1'b0));
      reset_req_n = 1'b1;
      @(negedge clk);
      check("R9 still held off", outs(), pk(4'hF, 4'h0, 1'b1, 1'b1, 1'b0));
      for (int k = 0; k < 100 && !run_en; k++) @(negedge clk);
      gap = cyc - t0;
      check("R9 release edge after fault fall", gap, HOLD + 1);
      check("R4 cleared after reset cycle", outs(), pk(4'h0, 4'h0, 1'b1, 1'b1, 1'b1));

      // R3: latched thermal shutdown
      mode = 3'b101;
      therm_sd = 1'b1;
      @(negedge clk);
      check("R3 thermal shutdown", outs(), pk(4'hF, 4'h0, 1'b0, 1'b0, 1'b1));
      therm_sd = 1'b0;
      repeat (2) @(negedge clk);
      check("R3 thermal latched", outs(), pk(4'hF, 4'h0, 1'b0, 1'b0, 1'b1));
      reset_req_n = 1'b0;
      repeat (HOLD + 5) @(negedge clk);
      reset_req_n = 1'b1;
      @(negedge clk);
      check("R3 cleared after reset cycle", outs(), pk(4'h0, 4'h0, 1'b1, 1'b1, 1'b1));

      // R4 with mode 3'b100: any channel stops all four
      mode = 3'b100;
      ch_ovl = 4'b1000;
      @(negedge clk);
      check("R4 R5 parallel overload", outs(), pk(4'hF, 4'h0, 1'b0, 1'b1, 1'b1));
      ch_ovl = '0;
      @(negedge clk);
      finish_run();
   end
endmodule